// File: doc/BRIEF.md
# Out-of-Order Issue Window with Grouped In-Order Retirement

This block is a 24-slot window of micro-operations sitting between instruction decode and six execution-unit classes. Decode writes up to two micro-ops per cycle at the tail. Each slot records its unit class, whether its operands are ready, whether it has been sent to a unit, whether the unit has reported it finished, and whether it is the final micro-op of its parent instruction. Each cycle the window sends at most one operation to each unit class that is not busy. For each class it picks the oldest waiting entry, wherever that entry sits in the window.

Operand-wakeup and completion reports arrive by slot tag. Finished entries leave from the head in program order, at most four per cycle. An instruction is only committed when all of its micro-ops have finished, so an instruction is never partly committed. A flush empties the window in a single cycle. Renaming, forwarding, the units themselves and decode stay outside the block and appear only as ready, busy and completion inputs.

Top module: `sched_window`

## Requirements
- R1: After reset the window is empty. No issue and no retirement are signalled, dispatch is accepted, and the first slot tag handed out is 0.
- R2: Valid dispatch lanes are written in lane order into consecutive tags starting at the tail, wrapping modulo 24. `disp_tag` for lane i is tail plus the number of valid lanes below i. The lanes are written only when `disp_accept` is high.
- R3: An entry can issue only if it is occupied, operand-ready, not yet issued, and its class is not busy. Class codes are 0 store, 1 load, 2 branch, 3 integer/multimedia X, 4 integer/multimedia Y, 5 floating point. Output i of `issue_valid`/`issue_tag` belongs to class i, and an issued entry never issues again.
- R4: When several eligible entries share a class, the one closest to the head in program order is issued.
- R5: A wakeup by tag marks an occupied entry ready, and the entry can issue from the next cycle on. A dispatched entry may also arrive already ready. A wakeup to a free slot has no effect.
- R6: A completion report by tag marks an occupied entry done, and it counts from the next cycle on. A report to a free slot has no effect, even if that slot is written in the same cycle.
- R7: `ret_count` entries leave from the head in order, and `ret_tag` lane k holds head+k. The count is the largest n ≤ 4 such that the first n entries are all done and entry n-1 ends an instruction. Instructions are at most four micro-ops long.
- R8: Issued entries keep their slot until they retire, and dispatch never overwrites an occupied slot.
- R9: A flush suppresses issue, retirement and dispatch in its cycle. It empties every slot and returns the head and tail to 0.
- R10: Dispatch stalls when the free slots are fewer than the valid lanes requested, and in that case no lane is written. Occupancy never exceeds 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the window |
| disp_valid | input | 2 | Dispatch lane valid |
| disp_cls | input | 6 | Unit class per lane, 3 bits each |
| disp_eoi | input | 2 | Lane holds last micro-op of its instruction |
| disp_rdy | input | 2 | Lane enters already operand-ready |
| disp_accept | output | 1 | All valid lanes are written this cycle |
| disp_tag | output | 10 | Slot tag per lane, 5 bits each |
| wake_valid | input | 2 | Wakeup port valid |
| wake_tag | input | 10 | Wakeup tags, 5 bits each |
| unit_busy | input | 6 | Unit class cannot take an operation |
| issue_valid | output | 6 | Issue to unit class i |
| issue_tag | output | 30 | Issued tag per class, 5 bits each |
| cmpl_valid | input | 2 | Completion port valid |
| cmpl_tag | input | 10 | Completed tags, 5 bits each |
| ret_count | output | 3 | Entries retired this cycle (0..4) |
| ret_tag | output | 20 | Tags at head+0..head+3, 5 bits each |

## Verification
A bad head pointer or done flag shows up on `ret_tag`/`ret_count` in the first cycle the head group finishes: tags come out of dispatch order, or a group retires before its last report. A stale issued flag or a wrong age order shows as a repeated or younger tag on `issue_tag` in the very cycle the entry is eligible. Occupancy errors show as a wrong `disp_accept` or a tag that collides with a live entry at the next dispatch. A reference queue in the bench follows every cycle, so each of these is caught within one clock of its first visible effect.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [2:0] {
    CL_STORE  = 3'd0,
    CL_LOAD   = 3'd1,
    CL_BRANCH = 3'd2,
    CL_INTX   = 3'd3,
    CL_INTY   = 3'd4,
    CL_FP     = 3'd5
  } unit_cls_e;

  // Advance a ring index by k (k < depth).
  function automatic int ring_add(input int p, input int k, input int depth);
    int s;
    s = p + k;
    return (s >= depth) ? s - depth : s;
  endfunction
endpackage

// File: rtl/sched_alloc.sv
module sched_alloc import sched_pkg::*; #(
  parameter int DEPTH  = 24,
  parameter int DISP_W = 2,
  parameter int TAG_W  = 5,
  parameter int CNT_W  = 5,
  parameter int ACC_W  = 2
) (
  input  logic [TAG_W-1:0]        tail,
  input  logic [CNT_W-1:0]        count,
  input  logic [DISP_W-1:0]       req,
  input  logic                    hold,
  output logic                    accept,
  output logic [DISP_W*TAG_W-1:0] lane_tag,
  output logic [ACC_W-1:0]        n_acc
);
  logic [ACC_W-1:0] n_req;
  logic [CNT_W-1:0] n_free;

  always_comb begin
    int off;
    off   = 0;
    n_req = '0;
    for (int i = 0; i < DISP_W; i++) begin
      lane_tag[i*TAG_W +: TAG_W] = TAG_W'(ring_add(int'(tail), off, DEPTH));
      if (req[i]) begin
        off   = off + 1;
        n_req = n_req + ACC_W'(1);
      end
    end
  end

  assign n_free = CNT_W'(DEPTH) - count;
  assign accept = !hold && (n_free >= CNT_W'(n_req));
  assign n_acc  = accept ? n_req : '0;
endmodule

// File: rtl/sched_pick.sv
module sched_pick import sched_pkg::*; #(
  parameter int DEPTH = 24,
  parameter int NCLS  = 6,
  parameter int CLS_W = 3,
  parameter int TAG_W = 5
) (
  input  logic [TAG_W-1:0]      head,
  input  logic [DEPTH-1:0]      elig,
  input  logic [DEPTH*CLS_W-1:0] cls,
  input  logic [NCLS-1:0]       busy,
  input  logic                  hold,
  output logic [NCLS-1:0]       pick_v,
  output logic [NCLS*TAG_W-1:0] pick_tag
);
  genvar c;
  generate
    for (c = 0; c < NCLS; c++) begin : g_cls
      logic             found;
      logic [TAG_W-1:0] sel;
      // Age scan from the head: the first hit is the oldest.
      always_comb begin
        int idx;
        found = 1'b0;
        sel   = '0;
        for (int k = 0; k < DEPTH; k++) begin
          idx = ring_add(int'(head), k, DEPTH);
          if (!found && elig[idx] && cls[idx*CLS_W +: CLS_W] == CLS_W'(c)) begin
            found = 1'b1;
            sel   = TAG_W'(idx);
          end
        end
      end
      assign pick_v[c] = found && !busy[c] && !hold;
      assign pick_tag[c*TAG_W +: TAG_W] = sel;
    end
  endgenerate
endmodule

// File: rtl/sched_retire.sv
module sched_retire import sched_pkg::*; #(
  parameter int DEPTH  = 24,
  parameter int RET_W  = 4,
  parameter int TAG_W  = 5,
  parameter int RCNT_W = 3
) (
  input  logic [TAG_W-1:0]       head,
  input  logic [DEPTH-1:0]       valid,
  input  logic [DEPTH-1:0]       done,
  input  logic [DEPTH-1:0]       eoi,
  input  logic                   hold,
  output logic [RCNT_W-1:0]      ret_n,
  output logic [RET_W*TAG_W-1:0] ret_tag
);
  logic [RCNT_W-1:0] n_grp;

  // Walk up to RET_W slots; commit up to the last instruction end seen.
  always_comb begin
    int  idx;
    logic run;
    run   = 1'b1;
    n_grp = '0;
    for (int k = 0; k < RET_W; k++) begin
      idx = ring_add(int'(head), k, DEPTH);
      ret_tag[k*TAG_W +: TAG_W] = TAG_W'(idx);
      if (run && valid[idx] && done[idx]) begin
        if (eoi[idx]) n_grp = RCNT_W'(k + 1);
      end else begin
        run = 1'b0;
      end
    end
  end

  assign ret_n = hold ? '0 : n_grp;
endmodule

// File: rtl/sched_window.sv
module sched_window import sched_pkg::*; #(
  parameter int DEPTH  = 24,
  parameter int NCLS   = 6,
  parameter int DISP_W = 2,
  parameter int NWAKE  = 2,
  parameter int NCMPL  = 2,
  parameter int RET_W  = 4,
  localparam int TAG_W  = $clog2(DEPTH),
  localparam int CLS_W  = $clog2(NCLS),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ACC_W  = $clog2(DISP_W + 1),
  localparam int RCNT_W = $clog2(RET_W + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic [DISP_W-1:0]       disp_valid,
  input  logic [DISP_W*CLS_W-1:0] disp_cls,
  input  logic [DISP_W-1:0]       disp_eoi,
  input  logic [DISP_W-1:0]       disp_rdy,
  output logic                    disp_accept,
  output logic [DISP_W*TAG_W-1:0] disp_tag,
  input  logic [NWAKE-1:0]        wake_valid,
  input  logic [NWAKE*TAG_W-1:0]  wake_tag,
  input  logic [NCLS-1:0]         unit_busy,
  output logic [NCLS-1:0]         issue_valid,
  output logic [NCLS*TAG_W-1:0]   issue_tag,
  input  logic [NCMPL-1:0]        cmpl_valid,
  input  logic [NCMPL*TAG_W-1:0]  cmpl_tag,
  output logic [RCNT_W-1:0]       ret_count,
  output logic [RET_W*TAG_W-1:0]  ret_tag
);
  // Per-slot state
  logic [DEPTH-1:0]       ent_v, ent_rdy, ent_iss, ent_done, ent_eoi;
  logic [DEPTH*CLS_W-1:0] ent_cls;
  logic [TAG_W-1:0]       head, tail;
  logic [CNT_W-1:0]       count;

  // Named internal events
  logic [DEPTH-1:0]  elig;
  logic [ACC_W-1:0]  n_acc;
  logic [TAG_W-1:0]  ret_last;

  assign elig = ent_v & ent_rdy & ~ent_iss;

  sched_alloc #(.DEPTH(DEPTH), .DISP_W(DISP_W), .TAG_W(TAG_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_alloc (
    .tail(tail), .count(count), .req(disp_valid), .hold(flush),
    .accept(disp_accept), .lane_tag(disp_tag), .n_acc(n_acc)
  );

  sched_pick #(.DEPTH(DEPTH), .NCLS(NCLS), .CLS_W(CLS_W), .TAG_W(TAG_W)) u_pick (
    .head(head), .elig(elig), .cls(ent_cls), .busy(unit_busy), .hold(flush),
    .pick_v(issue_valid), .pick_tag(issue_tag)
  );

  sched_retire #(.DEPTH(DEPTH), .RET_W(RET_W), .TAG_W(TAG_W), .RCNT_W(RCNT_W)) u_ret (
    .head(head), .valid(ent_v), .done(ent_done), .eoi(ent_eoi), .hold(flush),
    .ret_n(ret_count), .ret_tag(ret_tag)
  );

  always_comb begin
    ret_last = ret_tag[TAG_W-1:0];
    for (int k = 1; k < RET_W; k++)
      if (ret_count == RCNT_W'(k + 1)) ret_last = ret_tag[k*TAG_W +: TAG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v    <= '0;
      ent_rdy  <= '0;
      ent_iss  <= '0;
      ent_done <= '0;
      ent_eoi  <= '0;
      ent_cls  <= '0;
      head     <= '0;
      tail     <= '0;
      count    <= '0;
    end else if (flush) begin
      ent_v    <= '0;
      ent_iss  <= '0;
      ent_done <= '0;
      head     <= '0;
      tail     <= '0;
      count    <= '0;
    end else begin
      for (int k = 0; k < RET_W; k++)
        if (RCNT_W'(k) < ret_count) ent_v[ret_tag[k*TAG_W +: TAG_W]] <= 1'b0;
      for (int w = 0; w < NWAKE; w++)
        if (wake_valid[w] && ent_v[wake_tag[w*TAG_W +: TAG_W]])
          ent_rdy[wake_tag[w*TAG_W +: TAG_W]] <= 1'b1;
      for (int q = 0; q < NCMPL; q++)
        if (cmpl_valid[q] && ent_v[cmpl_tag[q*TAG_W +: TAG_W]])
          ent_done[cmpl_tag[q*TAG_W +: TAG_W]] <= 1'b1;
      for (int c = 0; c < NCLS; c++)
        if (issue_valid[c]) ent_iss[issue_tag[c*TAG_W +: TAG_W]] <= 1'b1;
      for (int i = 0; i < DISP_W; i++)
        if (disp_accept && disp_valid[i]) begin
          ent_v   [disp_tag[i*TAG_W +: TAG_W]] <= 1'b1;
          ent_rdy [disp_tag[i*TAG_W +: TAG_W]] <= disp_rdy[i];
          ent_iss [disp_tag[i*TAG_W +: TAG_W]] <= 1'b0;
          ent_done[disp_tag[i*TAG_W +: TAG_W]] <= 1'b0;
          ent_eoi [disp_tag[i*TAG_W +: TAG_W]] <= disp_eoi[i];
          ent_cls[disp_tag[i*TAG_W +: TAG_W]*CLS_W +: CLS_W] <= disp_cls[i*CLS_W +: CLS_W];
        end
      head  <= TAG_W'(ring_add(int'(head), int'(ret_count), DEPTH));
      tail  <= TAG_W'(ring_add(int'(tail), int'(n_acc), DEPTH));
      count <= count - CNT_W'(ret_count) + CNT_W'(n_acc);
    end
  end

  // ---------------- assertions ----------------
  genvar ga;
  generate
    for (ga = 0; ga < NCLS; ga++) begin : g_issue_chk
      // R3
      issue_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid[ga] |=> ent_iss[$past(issue_tag[ga*TAG_W +: TAG_W])]);
    end
    for (ga = 0; ga < DISP_W; ga++) begin : g_disp_chk
      // R8
      no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_accept && disp_valid[ga]) |-> !ent_v[disp_tag[ga*TAG_W +: TAG_W]]);
    end
  endgenerate

  // R7
  retire_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_count <= RCNT_W'(RET_W));

  // R7
  retire_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_count != '0) |-> (ent_v[ret_last] && ent_iss[ret_last] && ent_done[ret_last]));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && head == '0 && tail == '0 && ent_v == '0));

  // R10
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: tb/sched_window_test.sv
module sched_window_test;
  localparam int DEPTH = 24, NCLS = 6, DW = 2, NW = 2, NC = 2, RW = 4, TW = 5, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic [DW-1:0] disp_valid = '0, disp_eoi = '0, disp_rdy = '0;
  logic [DW*CW-1:0] disp_cls = '0;
  logic disp_accept;
  logic [DW*TW-1:0] disp_tag;
  logic [NW-1:0] wake_valid = '0;
  logic [NW*TW-1:0] wake_tag = '0;
  logic [NCLS-1:0] unit_busy = '0, issue_valid;
  logic [NCLS*TW-1:0] issue_tag;
  logic [NC-1:0] cmpl_valid = '0;
  logic [NC*TW-1:0] cmpl_tag = '0;
  logic [2:0] ret_count;
  logic [RW*TW-1:0] ret_tag;

  always #10 clk = ~clk;

  sched_window uut (.*);

  int n_chk = 0, n_fail = 0;
  // reference model, indexed by tag; ord holds live tags in dispatch order
  bit m_v[DEPTH], m_r[DEPTH], m_i[DEPTH], m_d[DEPTH], m_e[DEPTH];
  int m_c[DEPTH], m_lat[DEPTH];
  int ord[$];
  int m_tail = 0;
  // pending micro-op stream
  int pc[2], pe[2], pr[2], p_n = 0, g_left = 0;
  // knobs
  int disp_pct = 70, busy_pct = 30, wake_pct = 40, lat_max = 6, flush_pct = 0;
  bit cmpl_en = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear(input int tail0);
    for (int t = 0; t < DEPTH; t++) begin m_v[t] = 0; m_i[t] = 0; m_d[t] = 0; end
    ord.delete();
    m_tail = tail0;
  endtask

  task automatic idle();
    flush = 0; disp_valid = '0; disp_cls = '0; disp_eoi = '0; disp_rdy = '0;
    wake_valid = '0; wake_tag = '0; unit_busy = '0; cmpl_valid = '0; cmpl_tag = '0;
  endtask

  task automatic refill();
    while (p_n < 2) begin
      if (g_left == 0) g_left = 1 + $urandom % 3;
      pc[p_n] = $urandom % NCLS;
      pe[p_n] = (g_left == 1);
      pr[p_n] = $urandom % 2;
      g_left--;
      p_n++;
    end
  endtask

  // One random cycle: drive, compare against the model, advance the model.
  task automatic step();
    int offer, nc, nreq, t, n;
    bit acc;
    bit exp_iv[NCLS];
    int exp_it[NCLS];
    @(negedge clk);
    idle();
    refill();
    offer = ($urandom % 100 < disp_pct) ? 1 + $urandom % 2 : 0;
    for (int i = 0; i < offer; i++) begin
      disp_valid[i] = 1'b1;
      disp_cls[i*CW +: CW] = CW'(pc[i]);
      disp_eoi[i] = pe[i][0];
      disp_rdy[i] = pr[i][0];
    end
    for (int c = 0; c < NCLS; c++) unit_busy[c] = ($urandom % 100 < busy_pct);
    for (int w = 0; w < NW; w++) if ($urandom % 100 < wake_pct) begin
      wake_valid[w] = 1'b1;
      wake_tag[w*TW +: TW] = TW'($urandom % DEPTH);
    end
    nc = 0;
    begin
      int st;
      st = $urandom % DEPTH;
      for (int j = 0; j < DEPTH; j++) begin
        t = (st + j) % DEPTH;
        if (cmpl_en && nc < NC && m_v[t] && m_i[t] && !m_d[t] && m_lat[t] == 0) begin
          cmpl_valid[nc] = 1'b1; cmpl_tag[nc*TW +: TW] = TW'(t); nc++;
        end
      end
    end
    if (nc < NC && $urandom % 10 == 0) begin
      t = $urandom % DEPTH;
      if (!m_v[t]) begin cmpl_valid[nc] = 1'b1; cmpl_tag[nc*TW +: TW] = TW'(t); end
    end
    flush = ($urandom % 1000 < flush_pct * 10);
    #1;
    // dispatch
    nreq = offer;
    acc = !flush && (DEPTH - ord.size() >= nreq);
    chk(disp_accept == acc, (DEPTH - ord.size() < nreq) ? "R10" : "R2", disp_accept, acc, "disp_accept");
    if (acc) for (int i = 0; i < offer; i++)
      chk(disp_tag[i*TW +: TW] == TW'((m_tail + i) % DEPTH), "R2", disp_tag[i*TW +: TW], (m_tail + i) % DEPTH, "disp_tag");
    // issue: oldest eligible per class
    for (int c = 0; c < NCLS; c++) begin
      exp_iv[c] = 0; exp_it[c] = 0;
      foreach (ord[k]) begin
        t = ord[k];
        if (!exp_iv[c] && m_r[t] && !m_i[t] && m_c[t] == c) begin exp_iv[c] = 1; exp_it[c] = t; end
      end
      exp_iv[c] = exp_iv[c] && !unit_busy[c] && !flush;
      chk(issue_valid[c] == exp_iv[c], "R3", issue_valid[c], exp_iv[c], $sformatf("issue_valid[%0d]", c));
      if (exp_iv[c] && issue_valid[c])
        chk(issue_tag[c*TW +: TW] == TW'(exp_it[c]), "R4", issue_tag[c*TW +: TW], exp_it[c], $sformatf("issue_tag[%0d]", c));
    end
    // retirement scoreboard
    n = 0;
    if (!flush) for (int k = 0; k < RW && k < ord.size(); k++) begin
      if (!m_d[ord[k]]) break;
      if (m_e[ord[k]]) n = k + 1;
    end
    chk(ret_count == 3'(n), "R7", ret_count, n, "ret_count");
    for (int k = 0; k < n; k++)
      chk(ret_tag[k*TW +: TW] == TW'(ord[k]), "R7", ret_tag[k*TW +: TW], ord[k], "ret_tag order");
    // advance the model to the post-edge state
    if (flush) begin
      model_clear(0);
    end else begin
      for (int k = 0; k < n; k++) begin m_v[ord[0]] = 0; void'(ord.pop_front()); end
      for (int w = 0; w < NW; w++) if (wake_valid[w] && m_v[wake_tag[w*TW +: TW]]) m_r[wake_tag[w*TW +: TW]] = 1;
      for (int q = 0; q < NC; q++) if (cmpl_valid[q] && m_v[cmpl_tag[q*TW +: TW]]) m_d[cmpl_tag[q*TW +: TW]] = 1;
      for (int u = 0; u < DEPTH; u++) if (m_v[u] && m_i[u] && !m_d[u] && m_lat[u] > 0) m_lat[u]--;
      for (int c = 0; c < NCLS; c++) if (exp_iv[c]) begin m_i[exp_it[c]] = 1; m_lat[exp_it[c]] = $urandom % (lat_max + 1); end
      if (acc) for (int i = 0; i < offer; i++) begin
        t = m_tail;
        m_v[t] = 1; m_c[t] = pc[i]; m_e[t] = pe[i][0]; m_r[t] = pr[i][0]; m_i[t] = 0; m_d[t] = 0;
        ord.push_back(t);
        m_tail = (m_tail + 1) % DEPTH;
      end
    end
    if (acc && offer == 2) p_n = 0;
    else if (acc && offer == 1) begin pc[0] = pc[1]; pe[0] = pe[1]; pr[0] = pr[1]; p_n = 1; end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk); #1;
    chk(issue_valid == '0, "R1", issue_valid, 0, "issue after reset");
    chk(ret_count == '0, "R1", ret_count, 0, "retire after reset");
    chk(disp_accept == 1'b1, "R1", disp_accept, 1, "accept after reset");
    chk(disp_tag[TW-1:0] == '0, "R1", disp_tag[TW-1:0], 0, "first tag");
    // directed: flush, stray completion, late wakeup
    flush = 1'b1;
    @(negedge clk); idle(); cmpl_valid = 2'b01; cmpl_tag = '0;           // R6 to a free slot
    @(negedge clk); idle(); disp_valid = 2'b01; disp_cls = '0; disp_eoi = 2'b01; disp_rdy = '0;
    #1; chk(disp_accept && disp_tag[TW-1:0] == '0, "R9", disp_tag[TW-1:0], 0, "tag 0 after flush");
    @(negedge clk); idle(); #1;
    chk(ret_count == '0, "R6", ret_count, 0, "stray completion ignored");
    chk(issue_valid == '0, "R5", issue_valid, 0, "not ready, no issue");
    wake_valid = 2'b01; wake_tag = '0;
    #1; chk(issue_valid == '0, "R5", issue_valid, 0, "wakeup not same cycle");
    @(negedge clk); idle(); #1;
    chk(issue_valid == 6'b000001 && issue_tag[TW-1:0] == '0, "R5", issue_valid, 1, "issue after wakeup");
    @(negedge clk); idle(); #1;
    chk(issue_valid == '0, "R3", issue_valid, 0, "no second issue");
    chk(ret_count == '0, "R6", ret_count, 0, "not done yet");
    cmpl_valid = 2'b01; cmpl_tag = '0;
    #1; chk(ret_count == '0, "R6", ret_count, 0, "completion not same cycle");
    @(negedge clk); idle(); #1;
    chk(ret_count == 3'd1 && ret_tag[TW-1:0] == '0, "R7", ret_count, 1, "single retire");
    @(posedge clk);
    model_clear(1);
    // random phases
    repeat (300) step();
    cmpl_en = 0; disp_pct = 100;
    repeat (40) step();
    chk(ord.size() == DEPTH, "R10", ord.size(), DEPTH, "window filled");
    cmpl_en = 1; disp_pct = 70;
    repeat (200) step();
    flush_pct = 3;
    repeat (1500) step();
    flush_pct = 0; busy_pct = 80; lat_max = 2;
    repeat (500) step();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule